// File: doc/BRIEF.md
# Slow-Clock Real-Time Timer

The block keeps elapsed time in the slow clock domain. A programmable divider counts slow-clock cycles and gives one roll-over pulse per period. Each roll-over advances a 32-bit elapsed counter. A source-select bit in the mode word can instead advance the counter from an external 1 Hz tick. A 32-bit alarm value is compared with each new counter value.

Two sticky status flags record counter increments and alarm matches, and both clear when the status word is read. A single interrupt line raises when a flag is set and its enable bit is on. Software reaches the block through a small word-addressed register port: it writes the mode word to set the divider period, restart the timer, stop it, or pick the tick source.

Top module: `rtt_timer`

## Requirements
- R1: After reset the mode word reads 0x00008000, the counter reads 0, the alarm reads 0xFFFFFFFF, the status reads 0 and `irq` is low.
- R2: The divider field is mode bits 15:0. A value N of 3 or more gives one counter step every N cycles. A value of 0 gives one step every 65536 cycles.
- R3: Divider values 1 and 2 behave as a period of 3 cycles.
- R4: A mode write with bit 18 set clears the counter and restarts the divider with the newly written value, so that the first step lands exactly one period after the write edge. Bit 18 always reads 0.
- R5: While mode bit 20 is 1, the divider and the counter hold their values. After the bit is cleared, counting resumes from the held divider position.
- R6: With mode bit 24 set, the counter steps once for each cycle in which `tick_1hz` is high, and divider roll-overs are ignored. With bit 24 clear, the tick is ignored.
- R7: Mode bits 31:25, 23:21 and 19 read as 0, and writes to them have no effect.
- R8: Status bit 1 sets on every counter step. Status bit 0 sets when the stepped counter value equals the alarm. A read of the status address clears both bits, except that a bit being set in that same cycle stays set.
- R9: `irq` is high exactly when (status bit 1 and mode bit 17) or (status bit 0 and mode bit 16).
- R10: Address 0 is the mode word, address 1 is the alarm, address 2 is the counter (writes ignored) and address 3 is the status. `rdata` shows the addressed word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | Single-cycle 1 Hz pulse, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used for status clear) |
| addr | input | 2 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed word |
| irq | output | 1 | Combined interrupt |

## Verification
A divider position that has drifted shows at the ports as a counter step one or more cycles early or late. The bench therefore samples the counter one cycle before and exactly at each expected step. A lost restart leaves a nonzero counter at the first read after the write. A stuck or wrongly cleared flag shows on `irq` in the next cycle, and on the status word at the next read.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_MODE   = 2'd0;
  localparam logic [ADDR_W-1:0] A_ALARM  = 2'd1;
  localparam logic [ADDR_W-1:0] A_VALUE  = 2'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 2'd3;

  localparam int B_SRC   = 24;
  localparam int B_STOP  = 20;
  localparam int B_RERUN = 18;
  localparam int B_IEINC = 17;
  localparam int B_IEALM = 16;

  localparam int S_ALM = 0;
  localparam int S_INC = 1;
endpackage

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic [W-1:0] period,
  output logic         roll
);
  localparam logic [W-1:0] MIN_TERM = W'(2);

  logic [W-1:0] cnt_q, cnt_d, term;
  logic         at_end;

  always_comb begin
    if (period == '0)
      term = '1;
    else if (period < W'(3))
      term = MIN_TERM;
    else
      term = period - W'(1);
  end

  assign at_end = (cnt_q >= term);
  assign roll   = run & ~restart & at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)
      cnt_d = '0;
    else if (run)
      cnt_d = at_end ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  a_r5_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(cnt_q));
  a_r2_div_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> (cnt_q == '0));
  a_r4_div_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/rtt_counter.sv
module rtt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         restart,
  input  logic [W-1:0] alarm,
  output logic [W-1:0] value,
  output logic         ev_inc,
  output logic         ev_alm
);
  logic [W-1:0] val_q, val_d, nxt;

  assign nxt    = val_q + W'(1);
  assign ev_inc = step & ~restart;
  assign ev_alm = ev_inc & (nxt == alarm);
  assign value  = val_q;

  always_comb begin
    val_d = val_q;
    if (restart)
      val_d = '0;
    else if (step)
      val_d = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      val_q <= '0;
    else
      val_q <= val_d;
  end

  a_r4_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (val_q == '0));
  a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inc |=> (val_q == $past(val_q) + W'(1)));
  a_r5_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> $stable(val_q));
endmodule

// File: rtl/rtt_status.sv
module rtt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_inc,
  input  logic set_alm,
  input  logic clr,
  input  logic ie_inc,
  input  logic ie_alm,
  output logic flag_inc,
  output logic flag_alm,
  output logic irq
);
  logic inc_d, alm_d;

  always_comb begin
    inc_d = set_inc | (flag_inc & ~clr);
    alm_d = set_alm | (flag_alm & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_inc <= 1'b0;
      flag_alm <= 1'b0;
    end else begin
      flag_inc <= inc_d;
      flag_alm <= alm_d;
    end
  end

  assign irq = (flag_inc & ie_inc) | (flag_alm & ie_alm);

  a_r8_set_inc: assert property (@(posedge clk) disable iff (!rst_n)
    set_inc |=> flag_inc);
  a_r8_set_alm: assert property (@(posedge clk) disable iff (!rst_n)
    set_alm |=> flag_alm);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_inc && !set_alm) |=> (!flag_inc && !flag_alm));
endmodule

// File: rtl/rtt_timer.sv
module rtt_timer
  import rtt_pkg::*;
#(
  parameter int PRES_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq
);
  localparam logic [PRES_W-1:0] PRES_RST = PRES_W'(1) << (PRES_W - 1);

  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync <= 2'b00;
    else
      rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  logic              src_q, stop_q, ie_inc_q, ie_alm_q;
  logic [PRES_W-1:0] pres_q;
  logic [CNT_W-1:0]  alarm_q;
  logic              wr_mode, wr_alarm, restart, clr, roll, step, run;
  logic [CNT_W-1:0]  value;
  logic              ev_inc, ev_alm, flag_inc, flag_alm;
  logic              unused_wbits;

  assign wr_mode  = wr_en & (addr == A_MODE);
  assign wr_alarm = wr_en & (addr == A_ALARM);
  assign restart  = wr_mode & wdata[B_RERUN];
  assign clr      = rd_en & (addr == A_STATUS);
  assign run      = ~stop_q;
  assign step     = run & (src_q ? tick_1hz : roll);
  assign unused_wbits = ^{wdata[31:25], wdata[23:21], wdata[19]};

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      src_q    <= 1'b0;
      stop_q   <= 1'b0;
      ie_inc_q <= 1'b0;
      ie_alm_q <= 1'b0;
      pres_q   <= PRES_RST;
    end else if (wr_mode) begin
      src_q    <= wdata[B_SRC];
      stop_q   <= wdata[B_STOP];
      ie_inc_q <= wdata[B_IEINC];
      ie_alm_q <= wdata[B_IEALM];
      pres_q   <= wdata[PRES_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)
      alarm_q <= '1;
    else if (wr_alarm)
      alarm_q <= wdata;
  end

  rtt_prescaler #(.W(PRES_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .run     (run),
    .restart (restart),
    .period  (wr_mode ? wdata[PRES_W-1:0] : pres_q),
    .roll    (roll)
  );

  rtt_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .step    (step),
    .restart (restart),
    .alarm   (alarm_q),
    .value   (value),
    .ev_inc  (ev_inc),
    .ev_alm  (ev_alm)
  );

  rtt_status u_sts (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .set_inc  (ev_inc),
    .set_alm  (ev_alm),
    .clr      (clr),
    .ie_inc   (ie_inc_q),
    .ie_alm   (ie_alm_q),
    .flag_inc (flag_inc),
    .flag_alm (flag_alm),
    .irq      (irq)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      A_MODE: begin
        rdata[B_SRC]        = src_q;
        rdata[B_STOP]       = stop_q;
        rdata[B_IEINC]      = ie_inc_q;
        rdata[B_IEALM]      = ie_alm_q;
        rdata[PRES_W-1:0]   = pres_q;
      end
      A_ALARM:  rdata = alarm_q;
      A_VALUE:  rdata = value;
      default: begin
        rdata[S_INC] = flag_inc;
        rdata[S_ALM] = flag_alm;
      end
    endcase
  end

  a_r6_tick_ignored: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!src_q && !roll && !restart) |=> $stable(value));
  a_r10_alarm_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    !wr_alarm |=> $stable(alarm_q));
endmodule

// File: tb/rtt_timer_test.sv
`timescale 1ns/1ps
module rtt_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rtt_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  localparam int NROW = 8;
  localparam logic [15:0] T_PRES [NROW] = '{16'd5, 16'd3, 16'd1, 16'd2, 16'd7, 16'd4, 16'd4, 16'd9};
  localparam int          T_WAIT [NROW] = '{10, 9, 9, 6, 20, 3, 4, 8};
  localparam int          T_EXP  [NROW] = '{2, 3, 3, 2, 2, 0, 1, 0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic rd_sts(output logic [31:0] d);
    @(negedge clk);
    addr = 2'd3; rd_en = 1'b1;
    #1;
    d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R10 address map
    peek(2'd0, d); chk("R1 mode reset", d, 32'h0000_8000);
    peek(2'd1, d); chk("R1 alarm reset", d, 32'hFFFF_FFFF);
    peek(2'd2, d); chk("R1 value reset", d, 32'h0);
    peek(2'd3, d); chk("R1 status reset", d, 32'h0);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);

    // R2 R3 R4 table: restart with divider value, wait, read counter
    for (int i = 0; i < NROW; i++) begin
      wr(2'd0, 32'h0004_0000 | {16'h0, T_PRES[i]});
      repeat (T_WAIT[i]) @(negedge clk);
      peek(2'd2, d);
      chk((T_PRES[i] < 16'd3) ? "R3 short divider" : "R2/R4 period after restart", d, T_EXP[i]);
    end
    peek(2'd0, d); chk("R4 restart bit reads 0", d, 32'h0000_0009);

    // R2 zero divider means 65536 cycles
    wr(2'd0, 32'h0004_0000);
    repeat (65535) @(negedge clk);
    peek(2'd2, d); chk("R2 zero divider before step", d, 32'h0);
    @(negedge clk);
    peek(2'd2, d); chk("R2 zero divider step", d, 32'h1);

    // R9 flags set but interrupts not enabled
    chk("R9 irq gated off", {31'b0, irq}, 32'h0);
    rd_sts(d); chk("R8 increment flag", d & 32'h2, 32'h2);

    // R5 stop control
    wr(2'd0, 32'h0014_0003);
    rd_sts(d);
    rd_sts(d); chk("R8 read clears status", d, 32'h0);
    repeat (10) @(negedge clk);
    peek(2'd2, d); chk("R5 stopped counter holds", d, 32'h0);
    wr(2'd0, 32'h0000_0003);
    repeat (2) @(negedge clk);
    peek(2'd2, d); chk("R5 resume not early", d, 32'h0);
    @(negedge clk);
    peek(2'd2, d); chk("R5 resume from held divider", d, 32'h1);

    // R7 reserved bits, R6 tick source
    wr(2'd0, 32'hFFEF_0005);
    peek(2'd0, d); chk("R7 reserved bits dropped", d, 32'h0103_0005);
    rd_sts(d);
    rd_sts(d); chk("R8 status clear again", d, 32'h0);
    chk("R9 irq low with no flags", {31'b0, irq}, 32'h0);
    repeat (10) @(negedge clk);
    peek(2'd2, d); chk("R6 divider ignored in tick mode", d, 32'h0);
    tick(); tick(); tick();
    peek(2'd2, d); chk("R6 ticks counted", d, 32'h3);
    chk("R9 irq on increment", {31'b0, irq}, 32'h1);

    // R8 alarm, R10 alarm readback and read-only counter
    wr(2'd1, 32'h0000_0005);
    peek(2'd1, d); chk("R10 alarm readback", d, 32'h5);
    wr(2'd2, 32'h0000_1234);
    peek(2'd2, d); chk("R10 counter write ignored", d, 32'h3);
    tick();
    rd_sts(d); chk("R8 no alarm before match", d, 32'h2);
    tick();
    peek(2'd2, d); chk("R6 fifth tick", d, 32'h5);
    rd_sts(d); chk("R8 alarm on match", d, 32'h3);
    @(negedge clk);
    chk("R9 irq clears with flags", {31'b0, irq}, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule